// File: doc/BRIEF.md
# Dual Prescaled Down-Count Timer

This block holds two independent down-counting timers, a fast-tick timer (channel A, with an 8-bit prescaler) and a general timer (channel B, with a 16-bit prescaler). Each channel has a 32-bit live counter, a 32-bit reload value and a prescaler. The prescaler divides the clock by (scaler + 1), so a running counter steps down once per prescaler period. When a counter that is already at zero receives one more step, the channel emits a one-clock interrupt pulse. It then either reloads and keeps going, or stops, depending on a stored reload-on-zero bit.

Software reaches the block through a plain strobe interface. A write to a counter address sets that channel's reload value. A read of a counter address returns the live count. Each channel has its own scaler address. One shared control word holds four bits per channel: reload-on-zero, load-counter, run-enable and load-scaler. The two load bits are one-shot commands. The other two bits are stored. Read data is registered and appears one clock after the read strobe.

Top module: `timer_pair`

## Requirements
- R1: After reset both counters and both reload values are 0xFFFFFFFF, the channel A scaler is 0xFF, the channel B scaler is 0xFFFF, the control word reads 0 and both interrupt outputs are low.
- R2: A scaler write keeps only the low 8 bits for channel A (address 1) and the low 16 bits for channel B (address 3).
- R3: Once started with counter N and scaler S, a channel gives its first interrupt (N+1)*(S+1) clocks after the start write. The counter never changes by anything other than a single decrement, except through a load command or an expiry.
- R4: The control word sits at address 4. Channel B uses bits 0 (reload-on-zero), 1 (load counter from reload), 2 (run-enable) and 3 (load prescaler). Channel A uses bits 8 to 11 in the same roles. Bits 0, 2, 8 and 10 read back as written. The load bits always read 0.
- R5: With reload-on-zero set, an expiry loads the reload value and the channel keeps running, with a period of (R+1)*(S+1) clocks.
- R6: With reload-on-zero clear, an expiry stops the channel. Its counter stays at 0 and no further interrupt follows.
- R7: A read of address 0 (channel A) or 2 (channel B) returns the counter value held just before the clock edge that samples the read strobe. A write to those addresses changes only the reload value and leaves the counter untouched.
- R8: A control write with run-enable clear stops the channel, and its counter then holds its value.
- R9: A control write with run-enable set, made while the channel is already running, neither restarts its prescaler nor reloads its counter.
- R10: Each interrupt is a single-clock pulse on its own output and follows a step taken with the counter at zero. Activity on one channel never pulses the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid one clock after rd_en |
| irq_rtc | output | 1 | Channel A expiry pulse |
| irq_gpt | output | 1 | Channel B expiry pulse |

## Verification
A one-shot run on channel A with a small scaler measures the exact clock count to the first expiry. This separates an off-by-one in the prescaler from one in the counter. A periodic run on channel B checks the first interval and the later intervals after a reload. It shows whether the reload path restores the counter and the prescaler correctly. A free run with scaler 0 is read at a known cycle and then stopped, which pins down the live-read latency and the freeze. A second run-enable write in the middle of a count tells a correct design apart from one that restarts its prescaler on every control write.

// File: rtl/timer_pair_pkg.sv
package timer_pair_pkg;
  localparam int ADDR_W = 3;

  // register addresses
  localparam logic [ADDR_W-1:0] A_RTC_CNT = 3'd0;
  localparam logic [ADDR_W-1:0] A_RTC_SCL = 3'd1;
  localparam logic [ADDR_W-1:0] A_GPT_CNT = 3'd2;
  localparam logic [ADDR_W-1:0] A_GPT_SCL = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd4;

  // control word layout: per-channel field base and bit offsets
  localparam int GPT_CTL_BASE = 0;
  localparam int RTC_CTL_BASE = 8;
  localparam int CTL_RZ  = 0;
  localparam int CTL_LDC = 1;
  localparam int CTL_RUN = 2;
  localparam int CTL_LDS = 3;

  typedef struct packed {
    logic ld_scl;
    logic run_en;
    logic ld_cnt;
    logic reload_on_zero;
  } ctl_t;
endpackage

// File: rtl/tp_prescaler.sv
module tp_prescaler #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_scl,
  input  logic [SW-1:0] scl_in,
  input  logic          restart,
  input  logic          run,
  output logic [SW-1:0] scaler,
  output logic          tick
);
  logic [SW-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      scaler <= '1;
      pc     <= '1;
    end else begin
      if (wr_scl) scaler <= scl_in;
      if (restart) pc <= scaler;
      else if (run) begin
        if (pc == '0) pc <= scaler;
        else          pc <= pc - 1'b1;
      end
    end
  end

  assign tick = run && !restart && (pc == '0);
endmodule

// File: rtl/tp_channel.sv
module tp_channel
  import timer_pair_pkg::*;
#(
  parameter int CW = 32,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_reload,
  input  logic          wr_scl,
  input  logic          wr_ctl,
  input  logic [CW-1:0] wdata,
  input  ctl_t          ctl,
  output logic [CW-1:0] cnt,
  output logic [SW-1:0] scaler,
  output logic          rz,
  output logic          se,
  output logic          run,
  output logic          irq
);
  logic [CW-1:0] reload;
  logic          start, restart_pc, do_ld, tick;

  assign start      = wr_ctl && ctl.run_en && !run;
  assign restart_pc = start || (wr_ctl && ctl.ld_scl);
  assign do_ld      = wr_ctl && ctl.ld_cnt;

  tp_prescaler #(.SW(SW)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .wr_scl  (wr_scl),
    .scl_in  (wdata[SW-1:0]),
    .restart (restart_pc),
    .run     (run),
    .scaler  (scaler),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '1;
      reload <= '1;
      run    <= 1'b0;
      rz     <= 1'b0;
      se     <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (wr_reload) reload <= wdata;
      if (wr_ctl) begin
        rz <= ctl.reload_on_zero;
        se <= ctl.run_en;
        if (!ctl.run_en) run <= 1'b0;
        else if (!run)   run <= 1'b1;
      end
      if (do_ld) cnt <= reload;
      else if (tick) begin
        if (cnt == '0) begin
          irq <= 1'b1;
          if (rz) cnt <= reload;
          else    run <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/timer_pair.sv
module timer_pair
  import timer_pair_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int RTC_SCL_W = 8,
  parameter int GPT_SCL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq_rtc,
  output logic              irq_gpt
);
  localparam int NCH = 2;

  logic [NCH-1:0][CNT_W-1:0] cnt_a;
  logic [NCH-1:0][CNT_W-1:0] scl_a;
  logic [NCH-1:0]            rz_a, se_a, run_a, irq_a;
  logic                      wr_ctl;
  logic [CNT_W-1:0]          ctl_rb;

  assign wr_ctl = wr_en && (addr == A_CTRL);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int SW = (g == 0) ? RTC_SCL_W : GPT_SCL_W;
    localparam int CB = (g == 0) ? RTC_CTL_BASE : GPT_CTL_BASE;
    localparam logic [ADDR_W-1:0] ACNT = (g == 0) ? A_RTC_CNT : A_GPT_CNT;
    localparam logic [ADDR_W-1:0] ASCL = (g == 0) ? A_RTC_SCL : A_GPT_SCL;
    logic [SW-1:0] scl_w;

    tp_channel #(.CW(CNT_W), .SW(SW)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .wr_reload (wr_en && (addr == ACNT)),
      .wr_scl    (wr_en && (addr == ASCL)),
      .wr_ctl    (wr_ctl),
      .wdata     (wdata),
      .ctl       (ctl_t'(wdata[CB +: 4])),
      .cnt       (cnt_a[g]),
      .scaler    (scl_w),
      .rz        (rz_a[g]),
      .se        (se_a[g]),
      .run       (run_a[g]),
      .irq       (irq_a[g])
    );

    assign scl_a[g] = {{(CNT_W-SW){1'b0}}, scl_w};
  end

  assign irq_rtc = irq_a[0];
  assign irq_gpt = irq_a[1];

  always_comb begin
    ctl_rb = '0;
    ctl_rb[RTC_CTL_BASE + CTL_RZ]  = rz_a[0];
    ctl_rb[RTC_CTL_BASE + CTL_RUN] = se_a[0];
    ctl_rb[GPT_CTL_BASE + CTL_RZ]  = rz_a[1];
    ctl_rb[GPT_CTL_BASE + CTL_RUN] = se_a[1];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_RTC_CNT: rdata <= cnt_a[0];
        A_RTC_SCL: rdata <= scl_a[0];
        A_GPT_CNT: rdata <= cnt_a[1];
        A_GPT_SCL: rdata <= scl_a[1];
        A_CTRL:    rdata <= ctl_rb;
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/timer_pair_chk.sv
module timer_pair_chk #(
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic                  irq_rtc,
  input logic                  irq_gpt,
  input logic [1:0][CNT_W-1:0] cnt_a,
  input logic [1:0]            run_a,
  input logic [1:0]            rz_a
);
  // R3: outside loads and expiries a counter only holds or steps down by one
  assert_step_rtc_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && !irq_rtc) |->
      (cnt_a[0] == $past(cnt_a[0]) || cnt_a[0] == $past(cnt_a[0]) - 1'b1));
  assert_step_gpt_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && !irq_gpt) |->
      (cnt_a[1] == $past(cnt_a[1]) || cnt_a[1] == $past(cnt_a[1]) - 1'b1));

  // R10: a pulse only follows a step taken at zero
  assert_irq_zero_rtc_R10: assert property (@(posedge clk) disable iff (rst)
    irq_rtc |-> ($past(cnt_a[0]) == '0));
  assert_irq_zero_gpt_R10: assert property (@(posedge clk) disable iff (rst)
    irq_gpt |-> ($past(cnt_a[1]) == '0));

  // R6: expiry without reload-on-zero leaves the channel stopped
  assert_oneshot_stop_rtc_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_rtc && !$past(rz_a[0])) |-> !run_a[0]);
  assert_oneshot_stop_gpt_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_gpt && !$past(rz_a[1])) |-> !run_a[1]);

  // R8: a stopped channel holds its count unless written
  assert_hold_rtc_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(run_a[0]) && !$past(wr_en)) |-> $stable(cnt_a[0]));
  assert_hold_gpt_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(run_a[1]) && !$past(wr_en)) |-> $stable(cnt_a[1]));
endmodule

bind timer_pair timer_pair_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_timer_pair.sv
`timescale 1ns/1ps
module test_timer_pair;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_rtc, irq_gpt;

  int n_chk = 0;
  int n_fail = 0;
  bit cross_seen;

  always #5 clk = ~clk;

  timer_pair i_timer_pair (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_rtc(irq_rtc), .irq_gpt(irq_gpt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    #1 rd_en = 1'b0;
    d = rdata;
  endtask

  // counts clocks until the selected pulse; notes pulses on the other output
  task automatic wait_irq(input bit gpt, input int maxc, output int n);
    n = 0;
    for (int k = 1; k <= maxc; k++) begin
      @(posedge clk); #1;
      if (gpt ? irq_rtc : irq_gpt) cross_seen = 1'b1;
      if (gpt ? irq_gpt : irq_rtc) begin n = k; break; end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq_rtc", {31'd0, irq_rtc}, 32'd0);
    check("R1 irq_gpt", {31'd0, irq_gpt}, 32'd0);
    reg_read(3'd0, d); check("R1 rtc counter", d, 32'hFFFF_FFFF);
    reg_read(3'd1, d); check("R1 rtc scaler", d, 32'h0000_00FF);
    reg_read(3'd2, d); check("R1 gpt counter", d, 32'hFFFF_FFFF);
    reg_read(3'd3, d); check("R1 gpt scaler", d, 32'h0000_FFFF);
    reg_read(3'd4, d); check("R1 control", d, 32'd0);
  endtask

  task automatic t_scaler_mask();
    logic [31:0] d;
    reg_write(3'd1, 32'hABCD_1234);
    reg_read(3'd1, d); check("R2 rtc scaler 8 bits", d, 32'h0000_0034);
    reg_write(3'd3, 32'hABCD_1234);
    reg_read(3'd3, d); check("R2 gpt scaler 16 bits", d, 32'h0000_1234);
  endtask

  task automatic t_ctrl_bits();
    logic [31:0] d;
    reg_write(3'd0, 32'd7);
    reg_read(3'd0, d); check("R7 reload write leaves counter", d, 32'hFFFF_FFFF);
    reg_write(3'd4, 32'h0000_0200);
    reg_read(3'd0, d); check("R4 rtc load-counter bit 9", d, 32'd7);
    reg_read(3'd2, d); check("R4 gpt untouched by bit 9", d, 32'hFFFF_FFFF);
    reg_read(3'd4, d); check("R4 load bit reads 0", d, 32'd0);
    reg_write(3'd4, 32'h0000_0101);
    reg_read(3'd4, d); check("R4 reload-on-zero readback", d, 32'h0000_0101);
    reg_write(3'd4, 32'h0000_0000);
    reg_read(3'd4, d); check("R4 cleared readback", d, 32'd0);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    int n;
    reg_write(3'd1, 32'd1);
    reg_write(3'd0, 32'd3);
    reg_write(3'd4, 32'h0000_0200);
    cross_seen = 1'b0;
    reg_write(3'd4, 32'h0000_0C00);
    wait_irq(1'b0, 50, n);
    check("R3 first expiry (3+1)*(1+1)", n, 32'd8);
    @(posedge clk); #1;
    check("R10 rtc pulse one clock", {31'd0, irq_rtc}, 32'd0);
    wait_irq(1'b0, 20, n);
    check("R6 no expiry after stop", n, 32'd0);
    check("R10 gpt output quiet", {31'd0, cross_seen}, 32'd0);
    reg_read(3'd0, d); check("R6 counter held at 0", d, 32'd0);
    reg_read(3'd4, d); check("R4 run bit stored", d, 32'h0000_0400);
    reg_write(3'd4, 32'h0);
  endtask

  task automatic t_periodic();
    int n;
    reg_write(3'd3, 32'd2);
    reg_write(3'd2, 32'd2);
    cross_seen = 1'b0;
    reg_write(3'd4, 32'h0000_0007);
    wait_irq(1'b1, 50, n);
    check("R3 gpt first expiry (2+1)*(2+1)", n, 32'd9);
    @(posedge clk); #1;
    check("R10 gpt pulse one clock", {31'd0, irq_gpt}, 32'd0);
    wait_irq(1'b1, 50, n);
    check("R5 reload period", n, 32'd8);
    wait_irq(1'b1, 50, n);
    check("R5 steady period", n, 32'd9);
    check("R10 rtc output quiet", {31'd0, cross_seen}, 32'd0);
    reg_write(3'd4, 32'h0);
  endtask

  task automatic t_live_read();
    logic [31:0] d, d2;
    reg_write(3'd3, 32'd0);
    reg_write(3'd2, 32'd100);
    reg_write(3'd4, 32'h0000_0006);
    repeat (4) @(posedge clk);
    reg_read(3'd2, d); check("R7 live counter read", d, 32'd96);
    reg_write(3'd4, 32'h0);
    reg_read(3'd2, d); check("R8 counter after stop", d, 32'd94);
    repeat (10) @(posedge clk);
    reg_read(3'd2, d2); check("R8 counter frozen", d2, 32'd94);
  endtask

  task automatic t_no_restart();
    int n;
    reg_write(3'd3, 32'd3);
    reg_write(3'd2, 32'd1);
    reg_write(3'd4, 32'h0000_0006);
    repeat (2) @(posedge clk);
    reg_write(3'd4, 32'h0000_0004);
    wait_irq(1'b1, 50, n);
    check("R9 second run write does not restart", n, 32'd5);
    reg_write(3'd4, 32'h0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_scaler_mask();
    t_ctrl_bits();
    t_oneshot();
    t_periodic();
    t_live_read();
    t_no_restart();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule